// File: doc/BRIEF.md
# Single-Precision Floating-Point Compare Unit

This block compares two single-precision floating-point operands and returns a one-bit verdict, zero-extended to the integer result width, plus an invalid-operation flag. An operation select chooses between three relations: equality, less-than-or-equal and strict less-than. A fourth code means no operation. Equality is a quiet compare: only a signaling NaN raises the flag. Both ordering relations are signaling compares: any NaN operand raises the flag. Any NaN operand forces the verdict to zero.

Ordering is worked out directly from the raw encodings. The sign bits are compared first, then the magnitude bit patterns. Zeros of either sign are treated as one value. The comparison logic is combinational, and its verdict and flag are captured in one register stage. The magnitude comparator can be built as one wide compare or as an exponent/mantissa split. A parameter chooses between the two.

Top module: `fcmp_unit`

## Requirements
- R1: With select code 0 (equality), the verdict in bit 0 of `res_word` is 1 exactly when neither operand is a NaN and both encode the same value.
- R2: With select code 0, `flag_invalid` is 1 only when at least one operand is a signaling NaN. A signaling NaN has all exponent bits set, a nonzero fraction, and fraction bit 22 clear. A quiet NaN raises no flag under equality.
- R3: With select code 1 (less-than-or-equal), the verdict is 0 whenever either operand is a NaN, and `flag_invalid` is 1 for any NaN operand, quiet or signaling.
- R4: +0 and -0 count as equal. Any two operands whose bits 30:0 are all zero give an equality verdict of 1 and a less-than-or-equal verdict of 1, in either order.
- R5: When the sign bits differ and neither operand is a NaN, the first operand is less than or equal to the second exactly when it is negative or both are zeros.
- R6: When the sign bits match and neither operand is a NaN, ordering follows the unsigned compare of bits 30:0, inverted when both are negative. This covers infinities against finite values and subnormals against zero.
- R7: Bit-identical non-NaN operands always give a less-than-or-equal verdict of 1.
- R8: Select code 2 (strict less-than) gives 1 exactly when neither operand is a NaN and the first value is below the second; -0 is not below +0. Any NaN raises the flag.
- R9: When `in_valid` is low or the select is code 3 (idle), the next cycle shows `res_valid`, `res_word` and `flag_invalid` all low.
- R10: Bits `XLEN-1:1` of `res_word` are always zero.
- R11: While reset is asserted all outputs are zero. An accepted operation (valid high, select not idle) shows its result with `res_valid` high on the cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and select are presented this cycle |
| op_sel | input | 2 | 0 equality, 1 less-or-equal, 2 less-than, 3 idle |
| opnd_a | input | 32 | First operand, single-precision encoding |
| opnd_b | input | 32 | Second operand, single-precision encoding |
| res_valid | output | 1 | Registered result is valid |
| res_word | output | 32 | Verdict in bit 0, zero elsewhere |
| flag_invalid | output | 1 | Invalid-operation flag for the registered result |

## Verification
The checker assumes that `in_valid`, `op_sel` and both operands carry known values at every sampling edge. It also assumes the format is the default eight-bit exponent and 23-bit fraction, so that the NaN and zero tests it computes from the ports match the design's format. The stimulus never drives X or Z. It draws operands from weighted classes (NaNs of both kinds with random payloads, signed zeros, infinities, subnormals, normals and extremes). It often reuses or sign-flips the first operand as the second, so that the equal-value and opposite-sign cases come up often. It also covers all four select codes and occasional cycles with valid low.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

   typedef enum logic [1:0] {
      OP_EQ   = 2'd0,
      OP_LE   = 2'd1,
      OP_LT   = 2'd2,
      OP_IDLE = 2'd3
   } cmp_op_e;

   // Per-operand facts derived from the encoding alone
   typedef struct packed {
      logic is_nan;
      logic is_snan;
      logic mag_zero;
   } opnd_cls_t;

   // Relations between the operands, NaN handling not yet applied
   typedef struct packed {
      logic eq;
      logic le;
      logic lt;
   } order_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
   import fcmp_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [1+EXP_W+MAN_W-1:0] val,
   output opnd_cls_t                cls
);
   localparam int FP_W = 1 + EXP_W + MAN_W;

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             exp_ones;
   logic             man_nz;

   assign exp_f    = val[FP_W-2 -: EXP_W];
   assign man_f    = val[MAN_W-1:0];
   assign exp_ones = &exp_f;
   assign man_nz   = |man_f;

   always_comb begin
      cls          = '0;
      cls.is_nan   = exp_ones & man_nz;
      // quiet bit is the top fraction bit; clear means signaling
      cls.is_snan  = exp_ones & man_nz & ~man_f[MAN_W-1];
      cls.mag_zero = ~(|exp_f) & ~man_nz;
   end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
   import fcmp_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int MAN_W     = 23,
   parameter bit SPLIT_MAG = 1'b0
) (
   input  logic [1+EXP_W+MAN_W-1:0] a,
   input  logic [1+EXP_W+MAN_W-1:0] b,
   input  logic                     a_zero,
   input  logic                     b_zero,
   output order_t                   ord
);
   localparam int FP_W  = 1 + EXP_W + MAN_W;
   localparam int MAG_W = FP_W - 1;

   logic             sgn_a, sgn_b;
   logic [MAG_W-1:0] mag_a, mag_b;
   logic             mag_lt, mag_eq;
   logic             both_zero;
   logic             sgn_diff;

   assign sgn_a = a[FP_W-1];
   assign sgn_b = b[FP_W-1];
   assign mag_a = a[MAG_W-1:0];
   assign mag_b = b[MAG_W-1:0];

   generate
      if (SPLIT_MAG) begin : g_split
         logic [EXP_W-1:0] ea, eb;
         logic [MAN_W-1:0] ma, mb;
         logic             e_lt, e_eq, m_lt, m_eq;
         assign ea   = mag_a[MAG_W-1 -: EXP_W];
         assign eb   = mag_b[MAG_W-1 -: EXP_W];
         assign ma   = mag_a[MAN_W-1:0];
         assign mb   = mag_b[MAN_W-1:0];
         assign e_lt = ea < eb;
         assign e_eq = ea == eb;
         assign m_lt = ma < mb;
         assign m_eq = ma == mb;
         assign mag_lt = e_lt | (e_eq & m_lt);
         assign mag_eq = e_eq & m_eq;
      end else begin : g_flat
         assign mag_lt = mag_a < mag_b;
         assign mag_eq = mag_a == mag_b;
      end
   endgenerate

   assign both_zero = a_zero & b_zero;
   assign sgn_diff  = sgn_a ^ sgn_b;

   always_comb begin
      ord    = '0;
      ord.eq = (~sgn_diff & mag_eq) | both_zero;
      if (sgn_diff) begin
         ord.lt = sgn_a & ~both_zero;
      end else begin
         // negative pair: larger magnitude is the smaller value
         ord.lt = ~mag_eq & (sgn_a ^ mag_lt);
      end
      ord.le = ord.lt | ord.eq;
   end
endmodule

// File: rtl/fcmp_resolve.sv
module fcmp_resolve
   import fcmp_pkg::*;
(
   input  cmp_op_e   op,
   input  logic      fire,
   input  opnd_cls_t cls_a,
   input  opnd_cls_t cls_b,
   input  order_t    ord,
   output logic      hit,
   output logic      inv
);
   logic any_nan, any_snan;

   assign any_nan  = cls_a.is_nan | cls_b.is_nan;
   assign any_snan = cls_a.is_snan | cls_b.is_snan;

   // mag_zero is consumed by the order stage, not here
   logic unused_zero;
   assign unused_zero = cls_a.mag_zero ^ cls_b.mag_zero;

   always_comb begin
      hit = 1'b0;
      inv = 1'b0;
      if (fire) begin
         unique case (op)
            OP_EQ: begin
               hit = ~any_nan & ord.eq;
               inv = any_snan;
            end
            OP_LE: begin
               hit = ~any_nan & ord.le;
               inv = any_nan;
            end
            OP_LT: begin
               hit = ~any_nan & ord.lt;
               inv = any_nan;
            end
            default: begin
               hit = 1'b0;
               inv = 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
   import fcmp_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int MAN_W     = 23,
   parameter int XLEN      = 32,
   parameter bit SPLIT_MAG = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [1:0]               op_sel,
   input  logic [1+EXP_W+MAN_W-1:0] opnd_a,
   input  logic [1+EXP_W+MAN_W-1:0] opnd_b,
   output logic                     res_valid,
   output logic [XLEN-1:0]          res_word,
   output logic                     flag_invalid
);
   localparam int FP_W   = 1 + EXP_W + MAN_W;
   localparam int N_OPND = 2;

   generate
      if (EXP_W < 2 || MAN_W < 2) begin : g_bad_fmt
         $error("fcmp_unit: exponent and fraction need at least 2 bits each");
      end
      if (XLEN < 2) begin : g_bad_xlen
         $error("fcmp_unit: XLEN must be at least 2");
      end
   endgenerate

   cmp_op_e               op;
   logic                  fire;
   logic [FP_W-1:0]       opnd_v [N_OPND];
   opnd_cls_t             cls_v  [N_OPND];
   order_t                ord;
   logic                  hit, inv;
   logic                  vld_q, hit_q, inv_q;

   assign op        = cmp_op_e'(op_sel);
   assign fire      = in_valid & (op != OP_IDLE);
   assign opnd_v[0] = opnd_a;
   assign opnd_v[1] = opnd_b;

   generate
      for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
         fcmp_classify #(
            .EXP_W (EXP_W),
            .MAN_W (MAN_W)
         ) u_cls (
            .val (opnd_v[gi]),
            .cls (cls_v[gi])
         );
      end
   endgenerate

   fcmp_order #(
      .EXP_W     (EXP_W),
      .MAN_W     (MAN_W),
      .SPLIT_MAG (SPLIT_MAG)
   ) u_order (
      .a      (opnd_a),
      .b      (opnd_b),
      .a_zero (cls_v[0].mag_zero),
      .b_zero (cls_v[1].mag_zero),
      .ord    (ord)
   );

   fcmp_resolve u_resolve (
      .op    (op),
      .fire  (fire),
      .cls_a (cls_v[0]),
      .cls_b (cls_v[1]),
      .ord   (ord),
      .hit   (hit),
      .inv   (inv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         hit_q <= 1'b0;
         inv_q <= 1'b0;
      end else begin
         vld_q <= fire;
         hit_q <= hit;
         inv_q <= inv;
      end
   end

   assign res_valid    = vld_q;
   assign res_word     = {{(XLEN-1){1'b0}}, hit_q};
   assign flag_invalid = inv_q;

endmodule

// File: rtl/fcmp_unit_chk.sv
module fcmp_unit_chk #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int XLEN  = 32
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic [1:0]               op_sel,
   input logic [1+EXP_W+MAN_W-1:0] opnd_a,
   input logic [1+EXP_W+MAN_W-1:0] opnd_b,
   input logic                     res_valid,
   input logic [XLEN-1:0]          res_word,
   input logic                     flag_invalid
);
   localparam int FP_W = 1 + EXP_W + MAN_W;

   logic nan_a, nan_b, snan_a, snan_b, any_nan, any_snan, zeros, fire;

   assign nan_a    = (&opnd_a[FP_W-2 -: EXP_W]) && (|opnd_a[MAN_W-1:0]);
   assign nan_b    = (&opnd_b[FP_W-2 -: EXP_W]) && (|opnd_b[MAN_W-1:0]);
   assign snan_a   = nan_a && !opnd_a[MAN_W-1];
   assign snan_b   = nan_b && !opnd_b[MAN_W-1];
   assign any_nan  = nan_a || nan_b;
   assign any_snan = snan_a || snan_b;
   assign zeros    = (opnd_a[FP_W-2:0] == '0) && (opnd_b[FP_W-2:0] == '0);
   assign fire     = in_valid && (op_sel != 2'd3);

   AST_EQ_QUIET_NAN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 2'd0 && !any_snan) |=> !flag_invalid); // R2

   AST_EQ_SNAN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 2'd0 && any_snan) |=> flag_invalid); // R2

   AST_ORDER_NAN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_sel == 2'd1 || op_sel == 2'd2) && any_nan)
      |=> (flag_invalid && res_word == '0)); // R3

   AST_ZERO_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel != 2'd2 && op_sel != 2'd3 && zeros) |=> res_word[0]); // R4

   AST_SAME_BITS_LE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 2'd1 && opnd_a == opnd_b && !any_nan) |=> res_word[0]); // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> (!res_valid && !flag_invalid && res_word == '0)); // R9

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      res_word[XLEN-1:1] == '0); // R10

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> res_valid); // R11

endmodule

bind fcmp_unit fcmp_unit_chk #(
   .EXP_W (EXP_W),
   .MAN_W (MAN_W),
   .XLEN  (XLEN)
) u_chk (.*);

// File: tb/fcmp_unit_bench.sv
module fcmp_unit_bench;

   localparam logic [31:0] POS_ONE  = 32'h3F80_0000;
   localparam logic [31:0] NEG_ONE  = 32'hBF80_0000;
   localparam logic [31:0] POS_INF  = 32'h7F80_0000;
   localparam logic [31:0] NEG_INF  = 32'hFF80_0000;
   localparam logic [31:0] POS_MAX  = 32'h7F7F_FFFF;
   localparam logic [31:0] NEG_MAX  = 32'hFF7F_FFFF;
   localparam logic [31:0] QNAN     = 32'h7FC0_0000;
   localparam logic [31:0] SNAN     = 32'h7F80_0001;
   localparam logic [31:0] POS_ZERO = 32'h0000_0000;
   localparam logic [31:0] NEG_ZERO = 32'h8000_0000;
   localparam logic [31:0] POS_SUB  = 32'h0000_0001;
   localparam logic [31:0] NEG_SUB  = 32'h8000_0001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  op_sel = 2'd3;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic        res_valid;
   logic [31:0] res_word;
   logic        flag_invalid;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   fcmp_unit u_fcmp_unit (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .op_sel       (op_sel),
      .opnd_a       (opnd_a),
      .opnd_b       (opnd_b),
      .res_valid    (res_valid),
      .res_word     (res_word),
      .flag_invalid (flag_invalid)
   );

   function automatic logic f_nan(logic [31:0] v);
      return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
   endfunction

   function automatic logic f_snan(logic [31:0] v);
      return f_nan(v) && !v[22];
   endfunction

   // signed ordering key: both zeros map to 0
   function automatic logic signed [32:0] f_key(logic [31:0] v);
      logic signed [32:0] m;
      m = $signed({2'b00, v[30:0]});
      return v[31] ? -m : m;
   endfunction

   task automatic ref_cmp(input logic vld, input logic [1:0] op,
                          input logic [31:0] a, input logic [31:0] b,
                          output logic r, output logic i);
      logic nan_any, snan_any;
      nan_any  = f_nan(a) || f_nan(b);
      snan_any = f_snan(a) || f_snan(b);
      r = 1'b0;
      i = 1'b0;
      if (vld) begin
         case (op)
            2'd0: begin r = !nan_any && (f_key(a) == f_key(b)); i = snan_any; end
            2'd1: begin r = !nan_any && (f_key(a) <= f_key(b)); i = nan_any; end
            2'd2: begin r = !nan_any && (f_key(a) <  f_key(b)); i = nan_any; end
            default: begin r = 1'b0; i = 1'b0; end
         endcase
      end
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a falling edge; result checked at the next falling edge
   task automatic run_op(input logic vld, input logic [1:0] op,
                         input logic [31:0] a, input logic [31:0] b, input string tag);
      logic er, ei;
      in_valid = vld;
      op_sel   = op;
      opnd_a   = a;
      opnd_b   = b;
      ref_cmp(vld, op, a, b, er, ei);
      @(negedge clk);
      check({tag, " verdict"}, res_word, {31'd0, er});
      check({tag, " flag"}, {31'd0, flag_invalid}, {31'd0, ei});
      check({tag, " R11 valid"}, {31'd0, res_valid}, {31'd0, vld && op != 2'd3});
   endtask

   function automatic logic [31:0] pick_val();
      logic [31:0] v;
      logic        s;
      s = 1'($urandom);
      case ($urandom % 8)
         0: v = $urandom;
         1: v = {s, 31'd0};
         2: v = {s, 8'hFF, 23'd0};
         3: v = {s, 8'hFF, 1'b1, 22'($urandom)};
         4: v = {s, 8'hFF, 1'b0, 22'($urandom % 4194303 + 1)};
         5: v = {s, 8'h00, 23'($urandom % 8388607 + 1)};
         6: v = {s, 8'($urandom % 254 + 1), 23'($urandom)};
         default: v = {s, 31'h7F7F_FFFF};
      endcase
      return v;
   endfunction

   function automatic string pick_tag(logic [1:0] op, logic [31:0] a, logic [31:0] b);
      if (f_nan(a) || f_nan(b)) return (op == 2'd0) ? "R2" : "R3";
      if (op == 2'd2) return "R8";
      if (a[30:0] == 31'd0 && b[30:0] == 31'd0) return "R4";
      if (op == 2'd0) return "R1";
      if (a == b) return "R7";
      if (a[31] != b[31]) return "R5";
      return "R6";
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'h0C0F_FEE5));
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11 reset valid", {31'd0, res_valid}, 32'd0);
      check("R11 reset word", res_word, 32'd0);
      check("R11 reset flag", {31'd0, flag_invalid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      run_op(1'b1, 2'd0, POS_ONE, POS_ONE, "R1 eq same");
      run_op(1'b1, 2'd0, POS_ONE, 32'h3F80_0001, "R1 eq ulp apart");
      run_op(1'b1, 2'd0, POS_ONE, POS_ONE, "R10 upper bits");
      run_op(1'b1, 2'd0, QNAN, POS_ONE, "R2 eq quiet nan");
      run_op(1'b1, 2'd0, POS_ONE, SNAN, "R2 eq signaling nan");
      run_op(1'b1, 2'd0, QNAN, QNAN, "R2 eq nan self");
      run_op(1'b1, 2'd1, QNAN, POS_ONE, "R3 le quiet nan");
      run_op(1'b1, 2'd1, POS_ONE, SNAN, "R3 le signaling nan");
      run_op(1'b1, 2'd0, POS_ZERO, NEG_ZERO, "R4 eq zeros");
      run_op(1'b1, 2'd1, NEG_ZERO, POS_ZERO, "R4 le -0 +0");
      run_op(1'b1, 2'd1, POS_ZERO, NEG_ZERO, "R4 le +0 -0");
      run_op(1'b1, 2'd1, NEG_ONE, POS_ONE, "R5 le -x +x");
      run_op(1'b1, 2'd1, POS_ONE, NEG_ONE, "R5 le +x -x");
      run_op(1'b1, 2'd0, POS_ONE, NEG_ONE, "R5 eq +x -x");
      run_op(1'b1, 2'd1, POS_INF, POS_MAX, "R6 le +inf max");
      run_op(1'b1, 2'd1, POS_MAX, POS_INF, "R6 le max +inf");
      run_op(1'b1, 2'd1, NEG_INF, NEG_MAX, "R6 le -inf -max");
      run_op(1'b1, 2'd1, NEG_MAX, NEG_INF, "R6 le -max -inf");
      run_op(1'b1, 2'd1, POS_SUB, POS_ZERO, "R6 le sub +0");
      run_op(1'b1, 2'd1, POS_ZERO, POS_SUB, "R6 le +0 sub");
      run_op(1'b1, 2'd1, NEG_SUB, NEG_ZERO, "R6 le -sub -0");
      run_op(1'b1, 2'd1, POS_ONE, POS_ONE, "R7 le identical");
      run_op(1'b1, 2'd1, NEG_INF, NEG_INF, "R7 le -inf self");
      run_op(1'b1, 2'd2, POS_ONE, POS_ONE, "R8 lt identical");
      run_op(1'b1, 2'd2, NEG_ZERO, POS_ZERO, "R8 lt -0 +0");
      run_op(1'b1, 2'd2, NEG_ONE, POS_ONE, "R8 lt -x +x");
      run_op(1'b1, 2'd2, QNAN, POS_ONE, "R8 lt nan");
      run_op(1'b1, 2'd3, SNAN, POS_ONE, "R9 idle code");
      run_op(1'b0, 2'd1, SNAN, POS_ONE, "R9 valid low");
      run_op(1'b0, 2'd0, POS_ONE, POS_ONE, "R9 valid low eq");

      for (int k = 0; k < 3000; k++) begin
         logic [31:0] a, b;
         logic [1:0]  op;
         logic        vld;
         a = pick_val();
         case ($urandom % 8)
            0, 1: b = a;
            2:    b = a ^ 32'h8000_0000;
            default: b = pick_val();
         endcase
         op  = 2'($urandom);
         vld = ($urandom % 16) != 0;
         if (!vld || op == 2'd3) run_op(vld, op, a, b, "R9 random");
         else                    run_op(vld, op, a, b, pick_tag(op, a, b));
      end

      in_valid = 1'b0;
      op_sel   = 2'd3;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule